// File: doc/BRIEF.md
# Storage-Immediate Test and Add Unit

This unit carries out one instruction at a time that pairs an operand held in memory with an 8-bit immediate. A caller presents an operation code, a base-register field with the value of that register, a signed displacement and the immediate, then pulses `start`. The unit forms the effective address and reads the operand through a simple request/response memory port. It then computes a 2-bit condition code. For the two add forms it also writes the sum back to the same address.

Four operations are supported. Test-under-mask reports whether the mask-selected bits of a byte are all clear, mixed or all set. Compare treats a byte and the immediate as unsigned numbers. The 32-bit and 64-bit adds sign-extend the immediate, add it to a memory word and report overflow. A one-cycle `done` pulse marks completion, and `cc` keeps its value until the next completion.

Top module: `si_imm_engine`

## Requirements
- R1: The operand address on `mem_addr` is the base value plus the sign-extended displacement, wrapping at the address width. When `base_fld` is 0 the base value is replaced by zero.
- R2: Operation code 0 is test-under-mask. It ANDs the memory byte with `imm`. `cc` is 0 when the result is zero, including every case with a zero mask. `cc` is 3 when the result equals the mask and 1 otherwise.
- R3: Operation code 1 is an unsigned comparison of the memory byte with `imm`. `cc` is 0 when they are equal, 1 when the memory byte is lower and 2 when it is higher. It is never 3.
- R4: Operation code 2 adds the sign-extended `imm` to the 32-bit word in `mem_rdata[31:0]`. `cc` is 3 on signed overflow; otherwise it is 0 for a zero sum, 1 for a negative sum and 2 for a positive sum. The sum is written back in `mem_wdata[31:0]` with the upper bits zero.
- R5: Operation code 3 adds the sign-extended `imm` to the 64-bit `mem_rdata`. Overflow and the `cc` encoding are the same as in R4, taken on 64 bits, and the 64-bit sum is written back.
- R6: A write (`mem_req` and `mem_we` both high) happens only for codes 2 and 3. It is issued in the cycle after the cycle in which `mem_rvalid` was sampled high, to the same address as the read. Codes 0 and 1 never write.
- R7: The read request is a single cycle with `mem_req` high and `mem_we` low, in the cycle after `start` is sampled. `mem_size` is log2 of the access size in bytes: 0 for codes 0 and 1, 2 for code 2 and 3 for code 3. Read data arrives right-aligned, and bits above the access size are ignored.
- R8: `done` is a one-cycle pulse. For codes 0 and 1 it comes one cycle after `mem_rvalid` is sampled; for codes 2 and 3 it comes one cycle after the write. `cc` changes only in a cycle where `done` is high.
- R9: `busy` is high from the read cycle through the `done` cycle's predecessor. A `start` sampled while `busy` is high is ignored, and the operation in flight keeps its code, address and immediate.
- R10: While `rst_n` is low, `mem_req`, `mem_we`, `busy`, `done` and `cc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | Operation code: 0 test, 1 compare, 2 add 32, 3 add 64 |
| base_fld | input | BFLD_W | Base register field; 0 means no base |
| base_val | input | ADDR_W | Contents of the selected base register |
| disp | input | DISP_W | Signed displacement |
| imm | input | 8 | Immediate mask or addend |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access byte address |
| mem_size | output | 2 | log2 of access size in bytes |
| mem_wdata | output | 64 | Write data, right-aligned |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, right-aligned |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Completion pulse |
| cc | output | 2 | Condition code of the last completed operation |

## Verification
The read request is due in the first cycle after `start` is sampled. Each result is then timed from the cycle in which `mem_rvalid` is sampled: `done` and `cc` one cycle later for test and compare; the write one cycle later and `done` two cycles later for the adds. The bench runs a behavioural model that steps at the same edge the design does, using the inputs that edge sampled. At every falling edge it compares request, write enable, address, size, write data, `busy`, `done` and `cc`, so an early or late result shows up as a mismatch in that exact cycle. Read latency is varied from one to three cycles, and a second `start` is raised mid-operation to show it is ignored.

// File: rtl/si_pkg.sv
package si_pkg;

  typedef enum logic [1:0] {
    SI_TM    = 2'd0,
    SI_CMP   = 2'd1,
    SI_ADD32 = 2'd2,
    SI_ADD64 = 2'd3
  } si_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } si_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WT,
    ST_WR
  } si_state_e;

  localparam int unsigned SI_DATA_W = 64;
  localparam int unsigned SI_IMM_W  = 8;

endpackage

// File: rtl/si_agen.sv
module si_agen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 20,
  parameter int unsigned BFLD_W = 4
) (
  input  logic [BFLD_W-1:0] base_fld_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] disp_x;
  logic [ADDR_W-1:0] base_eff;

  generate
    if (ADDR_W > DISP_W) begin : g_sext
      assign disp_x = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_x = disp_i[ADDR_W-1:0];
    end
  endgenerate

  // a zero base field selects no register at all
  assign base_eff = (base_fld_i == '0) ? '0 : base_val_i;
  assign addr_o   = base_eff + disp_x;

endmodule

// File: rtl/si_alu.sv
module si_alu
  import si_pkg::*;
(
  input  si_op_e                op_i,
  input  logic [SI_IMM_W-1:0]   imm_i,
  input  logic [SI_DATA_W-1:0]  rdata_i,
  output logic [1:0]            cc_o,
  output logic [SI_DATA_W-1:0]  wdata_o
);

  localparam int unsigned W32 = 32;

  logic [7:0]            byte_v;
  logic [7:0]            sel_v;
  logic [W32-1:0]        sum32;
  logic [SI_DATA_W-1:0]  sum64;
  logic                  ovf32;
  logic                  ovf64;

  function automatic logic [1:0] sum_cc(input logic ovf, input logic zero, input logic neg);
    if (ovf)       return 2'd3;
    else if (zero) return 2'd0;
    else if (neg)  return 2'd1;
    else           return 2'd2;
  endfunction

  always_comb begin
    byte_v = rdata_i[7:0];
    sel_v  = byte_v & imm_i;
    sum32  = rdata_i[W32-1:0] + {{(W32-SI_IMM_W){imm_i[SI_IMM_W-1]}}, imm_i};
    sum64  = rdata_i + {{(SI_DATA_W-SI_IMM_W){imm_i[SI_IMM_W-1]}}, imm_i};
    ovf32  = (rdata_i[W32-1] == imm_i[SI_IMM_W-1]) && (sum32[W32-1] != imm_i[SI_IMM_W-1]);
    ovf64  = (rdata_i[SI_DATA_W-1] == imm_i[SI_IMM_W-1]) &&
             (sum64[SI_DATA_W-1] != imm_i[SI_IMM_W-1]);
    cc_o    = 2'd0;
    wdata_o = {{(SI_DATA_W-W32){1'b0}}, sum32};
    unique case (op_i)
      SI_TM: begin
        if (sel_v == 8'h00)     cc_o = 2'd0;
        else if (sel_v == imm_i) cc_o = 2'd3;
        else                    cc_o = 2'd1;
      end
      SI_CMP: begin
        if (byte_v == imm_i)     cc_o = 2'd0;
        else if (byte_v < imm_i) cc_o = 2'd1;
        else                     cc_o = 2'd2;
      end
      SI_ADD32: cc_o = sum_cc(ovf32, sum32 == '0, sum32[W32-1]);
      SI_ADD64: begin
        cc_o    = sum_cc(ovf64, sum64 == '0, sum64[SI_DATA_W-1]);
        wdata_o = sum64;
      end
      default: cc_o = 2'd0;
    endcase
  end

  always_comb begin
    if (op_i == SI_TM && imm_i == 8'h00) begin
      assert_zero_mask_R2: assert (cc_o == 2'd0);
    end
    if (op_i == SI_CMP) begin
      assert_cmp_range_R3: assert (cc_o != 2'd3);
    end
  end

endmodule

// File: rtl/si_ctrl.sv
module si_ctrl
  import si_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  si_op_e                op_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [SI_IMM_W-1:0]   imm_i,
  input  logic                  rvalid_i,
  input  logic [1:0]            alu_cc_i,
  input  logic [SI_DATA_W-1:0]  alu_wdata_i,
  output si_op_e                op_o,
  output logic [SI_IMM_W-1:0]   imm_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [1:0]            mem_size_o,
  output logic [SI_DATA_W-1:0]  mem_wdata_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [1:0]            cc_o
);

  si_state_e             state_q, state_n;
  si_op_e                op_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [SI_IMM_W-1:0]   imm_q;
  logic [SI_DATA_W-1:0]  wdata_q;
  logic [1:0]            ccp_q;
  logic [1:0]            cc_q, cc_n;
  logic                  done_q, done_n;
  logic                  is_add;
  logic                  ld_en;
  logic                  cap_en;

  assign is_add = (op_q == SI_ADD32) || (op_q == SI_ADD64);
  assign ld_en  = (state_q == ST_IDLE) && start_i;
  assign cap_en = (state_q == ST_WT) && rvalid_i;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_n = ST_RD;
      ST_RD:   state_n = ST_WT;
      ST_WT:   if (rvalid_i) state_n = is_add ? ST_WR : ST_IDLE;
      ST_WR:   state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    done_n = (cap_en && !is_add) || (state_q == ST_WR);
    cc_n   = cc_q;
    if (cap_en && !is_add)    cc_n = alu_cc_i;
    else if (state_q == ST_WR) cc_n = ccp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= SI_TM;
      addr_q  <= '0;
      imm_q   <= '0;
      wdata_q <= '0;
      ccp_q   <= 2'd0;
      cc_q    <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      cc_q    <= cc_n;
      if (ld_en) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        imm_q  <= imm_i;
      end
      if (cap_en) begin
        wdata_q <= alu_wdata_i;
        ccp_q   <= alu_cc_i;
      end
    end
  end

  always_comb begin
    unique case (op_q)
      SI_ADD32: mem_size_o = SZ_WORD;
      SI_ADD64: mem_size_o = SZ_DWORD;
      default:  mem_size_o = SZ_BYTE;
    endcase
  end

  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign cc_o        = cc_q;
  assign op_o        = op_q;
  assign imm_o       = imm_q;

  assert_wr_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> $past(rvalid_i));
  assert_no_wr_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (op_q == SI_ADD32 || op_q == SI_ADD64));
  assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_cc_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_q != $past(cc_q)) |-> done_q);
  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(addr_q) && $stable(op_q) && $stable(imm_q)));

endmodule

// File: rtl/si_imm_engine.sv
module si_imm_engine
  import si_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 20,
  parameter int unsigned BFLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [BFLD_W-1:0] base_fld,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [7:0]        imm,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [63:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cc
);

  logic [ADDR_W-1:0]    ea;
  si_op_e               op_held;
  logic [SI_IMM_W-1:0]  imm_held;
  logic [1:0]           alu_cc;
  logic [SI_DATA_W-1:0] alu_wdata;

  si_agen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .BFLD_W (BFLD_W)
  ) u_agen (
    .base_fld_i (base_fld),
    .base_val_i (base_val),
    .disp_i     (disp),
    .addr_o     (ea)
  );

  si_alu u_alu (
    .op_i    (op_held),
    .imm_i   (imm_held),
    .rdata_i (mem_rdata),
    .cc_o    (alu_cc),
    .wdata_o (alu_wdata)
  );

  si_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .op_i        (si_op_e'(op)),
    .addr_i      (ea),
    .imm_i       (imm),
    .rvalid_i    (mem_rvalid),
    .alu_cc_i    (alu_cc),
    .alu_wdata_i (alu_wdata),
    .op_o        (op_held),
    .imm_o       (imm_held),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_size_o  (mem_size),
    .mem_wdata_o (mem_wdata),
    .busy_o      (busy),
    .done_o      (done),
    .cc_o        (cc)
  );

endmodule

// File: tb/sim_si_imm_engine.sv
module sim_si_imm_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [3:0]  base_fld;
  logic [31:0] base_val;
  logic [19:0] disp;
  logic [7:0]  imm;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;
  logic        busy, done;
  logic [1:0]  cc;

  always #10 clk = ~clk;

  si_imm_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_fld(base_fld),
    .base_val(base_val), .disp(disp), .imm(imm), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cc(cc)
  );

  logic [7:0]  mem [0:255];
  int          n_cmp = 0, n_bad = 0, cyc = 0, lat = 1, cnt = 0;
  logic [31:0] raddr;

  // reference model state
  int          m_ph = 0;
  logic [1:0]  m_op = 2'd0, m_cc = 2'd0, m_ccp = 2'd0;
  logic [31:0] m_addr = '0;
  logic [7:0]  m_imm = '0;
  logic        m_done = 1'b0;
  logic [63:0] m_wd = '0;

  function automatic logic [63:0] rd8(input logic [31:0] a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = mem[8'(a[7:0] + 8'(i))];
    return r;
  endfunction

  task automatic poke(input logic [7:0] a, input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) mem[8'(a + 8'(i))] = v[i*8 +: 8];
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic model_step();
    m_done = 1'b0;
    case (m_ph)
      0: if (start) begin
        int d;
        d = int'(disp);
        if (d >= (1 << 19)) d -= (1 << 20);
        m_op   = op;
        m_addr = ((base_fld == 4'd0) ? 32'd0 : base_val) + 32'(d);
        m_imm  = imm;
        m_ph   = 1;
      end
      1: m_ph = 2;
      2: if (mem_rvalid) begin
        longint iv, a, s;
        logic [7:0] b, sel;
        logic [63:0] a64, s64;
        logic [31:0] r;
        logic ovf;
        b  = mem_rdata[7:0];
        iv = longint'($signed(m_imm));
        if (m_op == 2'd0) begin
          sel = b & m_imm;
          m_cc = (sel == 8'd0) ? 2'd0 : ((sel == m_imm) ? 2'd3 : 2'd1);
          m_done = 1'b1; m_ph = 0;
        end else if (m_op == 2'd1) begin
          m_cc = (int'(b) == int'(m_imm)) ? 2'd0 : ((int'(b) < int'(m_imm)) ? 2'd1 : 2'd2);
          m_done = 1'b1; m_ph = 0;
        end else if (m_op == 2'd2) begin
          a = longint'($signed(mem_rdata[31:0]));
          s = a + iv;
          ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
          r = s[31:0];
          m_ccp = ovf ? 2'd3 : (r == 0) ? 2'd0 : ($signed(r) < 0) ? 2'd1 : 2'd2;
          m_wd = {32'd0, r};
          m_ph = 3;
        end else begin
          a64 = mem_rdata;
          s64 = a64 + 64'(iv);
          ovf = (iv >= 0) ? ($signed(s64) < $signed(a64)) : ($signed(s64) > $signed(a64));
          m_ccp = ovf ? 2'd3 : (s64 == 0) ? 2'd0 : ($signed(s64) < 0) ? 2'd1 : 2'd2;
          m_wd = s64;
          m_ph = 3;
        end
      end
      3: begin m_cc = m_ccp; m_done = 1'b1; m_ph = 0; end
      default: m_ph = 0;
    endcase
  endtask

  task automatic compare();
    string t;
    logic [1:0] esz;
    case (m_op)
      2'd0: t = "R2 cc";
      2'd1: t = "R3 cc";
      2'd2: t = "R4 cc";
      default: t = "R5 cc";
    endcase
    esz = (m_op == 2'd2) ? 2'd2 : (m_op == 2'd3) ? 2'd3 : 2'd0;
    chk("R9 busy", 64'(busy), 64'(m_ph != 0));
    chk("R7 mem_req", 64'(mem_req), 64'(m_ph == 1 || m_ph == 3));
    chk("R6 mem_we", 64'(mem_we), 64'(m_ph == 3));
    chk("R8 done", 64'(done), 64'(m_done));
    chk(t, 64'(cc), 64'(m_cc));
    if (m_ph == 1 || m_ph == 3) begin
      chk("R1 mem_addr", 64'(mem_addr), 64'(m_addr));
      chk("R7 mem_size", 64'(mem_size), 64'(esz));
    end
    if (m_ph == 3)
      chk((m_op == 2'd3) ? "R5 write data" : "R4 write data", mem_wdata, m_wd);
  endtask

  task automatic mem_step();
    mem_rvalid = 1'b0;
    if (mem_req && mem_we)
      for (int i = 0; i < (1 << mem_size); i++)
        mem[8'(mem_addr[7:0] + 8'(i))] = mem_wdata[i*8 +: 8];
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd8(raddr);
      end
    end
    if (mem_req && !mem_we) begin
      cnt   = lat;
      raddr = mem_addr;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      finish_run();
    end
    if (rst_n) begin
      model_step();
      compare();
    end
    mem_step();
  endtask

  task automatic run(input logic [1:0] o, input logic [3:0] bf, input logic [31:0] bv,
                     input logic [19:0] d, input logic [7:0] im, input int l, input bit intf);
    lat = l;
    op = o; base_fld = bf; base_val = bv; disp = d; imm = im;
    start = 1'b1;
    step();
    start = 1'b0;
    for (int k = 0; k < l + 6; k++) begin
      if (intf && k == 1) begin
        // R9: a second request mid-flight with different operands
        start = 1'b1; op = 2'd0; disp = 20'h000F0; imm = 8'h55; base_fld = 4'd0;
      end else begin
        start = 1'b0;
      end
      step();
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    rst_n = 1'b0; start = 1'b0; op = 2'd0; base_fld = '0; base_val = '0;
    disp = '0; imm = '0; mem_rvalid = 1'b0; mem_rdata = '0;
    for (int i = 0; i < 3; i++) step();
    chk("R10 reset mem_req", 64'(mem_req), 64'd0);
    chk("R10 reset mem_we", 64'(mem_we), 64'd0);
    chk("R10 reset busy", 64'(busy), 64'd0);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset cc", 64'(cc), 64'd0);
    rst_n = 1'b1;
    step();

    // R2 test under mask; R1 zero base field ignores base_val
    poke(8'h30, 64'hF3, 1);
    run(2'd0, 4'd0, 32'hDEAD_0000, 20'h00030, 8'hF0, 1, 1'b0);
    poke(8'h31, 64'h13, 1);
    run(2'd0, 4'd2, 32'h0000_1040, 20'hFFFF1, 8'hF0, 3, 1'b0);   // R1 negative disp
    poke(8'h32, 64'h0F, 1);
    run(2'd0, 4'd5, 32'h0000_0030, 20'h00002, 8'hF0, 2, 1'b0);
    poke(8'h33, 64'hFF, 1);
    run(2'd0, 4'd0, 32'h0, 20'h00033, 8'h00, 1, 1'b0);           // R2 zero mask

    // R3 unsigned compare
    poke(8'h34, 64'h80, 1);
    poke(8'h35, 64'h7F, 1);
    run(2'd1, 4'd0, 32'h0, 20'h00034, 8'h80, 1, 1'b0);
    run(2'd1, 4'd0, 32'h0, 20'h00035, 8'h80, 2, 1'b0);
    run(2'd1, 4'd0, 32'h0, 20'h00034, 8'h7F, 3, 1'b0);

    // R4 32-bit add
    poke(8'h40, 64'h7FFF_FFFF, 4);
    run(2'd2, 4'd1, 32'h0000_0040, 20'h00000, 8'h01, 1, 1'b0);
    chk("R4 stored overflow word", 64'(rd8(32'h40) & 64'hFFFF_FFFF), 64'h8000_0000);
    poke(8'h44, 64'd5, 4);
    run(2'd2, 4'd0, 32'h0, 20'h00044, 8'hFB, 2, 1'b0);
    poke(8'h48, 64'hA5A5_A5A5_0000_0000, 8);
    run(2'd2, 4'd0, 32'h0, 20'h00048, 8'hFF, 3, 1'b0);
    chk("R4 stored negative word", rd8(32'h48), 64'hA5A5_A5A5_FFFF_FFFF);
    poke(8'h4C, 64'd10, 4);
    run(2'd2, 4'd0, 32'h0, 20'h0004C, 8'h03, 1, 1'b0);

    // R5 64-bit add
    poke(8'h50, 64'h7FFF_FFFF_FFFF_FFFF, 8);
    run(2'd3, 4'd0, 32'h0, 20'h00050, 8'h01, 1, 1'b0);
    poke(8'h58, 64'h0000_0000_FFFF_FFFF, 8);
    run(2'd3, 4'd0, 32'h0, 20'h00058, 8'h01, 2, 1'b0);
    chk("R5 stored carry dword", rd8(32'h58), 64'h0000_0001_0000_0000);
    poke(8'h60, 64'h8000_0000_0000_0000, 8);
    run(2'd3, 4'd0, 32'h0, 20'h00060, 8'hFF, 3, 1'b0);
    poke(8'h68, 64'h0, 8);
    run(2'd3, 4'd0, 32'h0, 20'h00068, 8'h80, 1, 1'b0);
    chk("R5 stored negative dword", rd8(32'h68), 64'hFFFF_FFFF_FFFF_FF80);

    // R9 start while busy is ignored
    poke(8'h70, 64'd100, 4);
    run(2'd2, 4'd0, 32'h0, 20'h00070, 8'h07, 2, 1'b1);
    chk("R9 in-flight add result", 64'(rd8(32'h70) & 64'hFFFF_FFFF), 64'd107);
    chk("R9 ignored request left byte", 64'(mem[8'hF0]), 64'(8'(8'hF0 * 37 + 11)));

    for (int i = 0; i < 3; i++) step();
    finish_run();
  end

endmodule